// File: doc/BRIEF.md
# Sequential Next-Block Prefetch Controller

This controller sits between a cache lookup stage and the port that fetches blocks from the next memory level. Each accepted lookup supplies a block address, a hit flag and the line's touched bit. From these the controller decides whether to request the block itself (a demand fetch) and whether to request the following block (a prefetch). The requests pass through a small request queue to a memory port with a valid/ready handshake. Each request carries a one-bit tag that marks it as demand or prefetch.

A mode input selects the policy. In always-prefetch mode, the first reference to a block requests the next block. A first reference is a miss, or a hit on a line whose touched bit is still clear. In prefetch-on-miss mode, only a miss requests the next block, and then the missing block and its successor are requested together. Demand requests are never lost: the lookup is stalled while the queue is full. A prefetch is dropped if no slot is left for it after the demand. A prefetch is also suppressed if its address is already waiting in the queue. Two counters report how many demand and prefetch requests have been queued.

Top module: `blk_prefetch_ctrl`

## Requirements
- R1: After reset the queue is empty, `mem_valid` is 0, `lk_ready` is 1 and both counters are 0.
- R2: A miss accepted in either mode queues a demand for the looked-up block (`mem_kind`=0), followed by a prefetch for that block plus one (`mem_kind`=1). The demand always leaves first. The touched bit is ignored on a miss.
- R3: With `pf_always`=0 (prefetch-on-miss), an accepted hit queues nothing, whatever the touched bit holds.
- R4: With `pf_always`=1, a hit whose touched bit is 0 queues exactly one prefetch, for the block plus one, and no demand.
- R5: With `pf_always`=1, a hit whose touched bit is 1 queues nothing.
- R6: `lk_ready` is 0 while all `DEPTH` slots are occupied, so a demand is stalled and never lost. A prefetch is dropped when no free slot remains after the demand of the same lookup. A pop in the same cycle does not free a slot.
- R7: A prefetch whose address equals any entry held in the queue at the start of the cycle is not queued.
- R8: The next-block address wraps modulo 2^`AW`: the all-ones block prefetches block 0.
- R9: `cnt_demand` and `cnt_prefetch` each add one for every request of their kind that is queued, and they are unchanged when no request of that kind is queued.
- R10: Requests leave in the order they were queued. While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr` and `mem_kind` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_always | input | 1 | 1 = always-prefetch, 0 = prefetch-on-miss |
| lk_valid | input | 1 | Lookup result present |
| lk_ready | output | 1 | Lookup accepted this cycle when high |
| lk_addr | input | AW | Referenced block address |
| lk_hit | input | 1 | 1 = lookup hit |
| lk_touched | input | 1 | Touched bit of the hit line (1 = already referenced) |
| mem_valid | output | 1 | Request at head of queue |
| mem_ready | input | 1 | Memory port accepts the head request |
| mem_addr | output | AW | Requested block address |
| mem_kind | output | 1 | 0 = demand, 1 = prefetch |
| cnt_demand | output | CW | Demand requests queued |
| cnt_prefetch | output | CW | Prefetch requests queued |

## Verification
A single lookup can need two queue writes (demand and prefetch) in the same cycle, competing with a pop and with the duplicate check against pending entries. The bench stalls the memory port to fill the queue to one free slot, then issues a miss. It judges that the demand takes the last slot and the prefetch is dropped. It also holds a lookup against a full queue while releasing exactly one pop, and checks that the stalled demand is accepted afterwards in the right order. A second case issues a prefetch whose address duplicates a queued one, and checks the drained stream for its absence.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic {
    REQ_DEMAND   = 1'b0,
    REQ_PREFETCH = 1'b1
  } req_kind_e;
endpackage

// File: rtl/pf_trigger.sv
module pf_trigger #(
  parameter int AW = 16
) (
  input  logic          pf_always,
  input  logic          fire,
  input  logic          hit,
  input  logic          touched,
  input  logic [AW-1:0] addr,
  output logic          want_dem,
  output logic          want_pf,
  output logic [AW-1:0] pf_addr
);
  logic first_ref;

  always_comb begin
    first_ref = !hit || !touched;
    want_dem  = fire && !hit;
    want_pf   = fire && (pf_always ? first_ref : !hit);
    pf_addr   = addr + AW'(1);
  end
endmodule

// File: rtl/pf_dup_check.sv
module pf_dup_check #(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0]         ent_live,
  input  logic [AW-1:0]            probe,
  output logic                     match
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
    assign hit_vec[j] = ent_live[j] && (ent_addr[j] == probe);
  end

  assign match = |hit_vec;
endmodule

// File: rtl/pf_req_queue.sv
module pf_req_queue #(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNTW = PW + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               n_push,
  input  logic [AW-1:0]            a0,
  input  logic                     k0,
  input  logic [AW-1:0]            a1,
  input  logic                     k1,
  input  logic                     pop,
  output logic [AW-1:0]            head_addr,
  output logic                     head_kind,
  output logic [CNTW-1:0]          cnt,
  output logic [DEPTH-1:0][AW-1:0] ent_addr,
  output logic [DEPTH-1:0]         ent_live
);
  logic [AW-1:0]   addr_mem [DEPTH];
  logic            kind_mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] cnt_q;
  logic [PW-1:0]   wr_nxt;

  assign wr_nxt = wr_ptr + PW'(1);

  always_ff @(posedge clk) begin
    if (n_push != 2'd0) begin
      addr_mem[wr_ptr] <= a0;
      kind_mem[wr_ptr] <= k0;
    end
    if (n_push == 2'd2) begin
      addr_mem[wr_nxt] <= a1;
      kind_mem[wr_nxt] <= k1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(n_push);
      if (pop) rd_ptr <= rd_ptr + PW'(1);
      cnt_q  <= cnt_q + CNTW'(n_push) - CNTW'(pop);
    end
  end

  assign head_addr = addr_mem[rd_ptr];
  assign head_kind = kind_mem[rd_ptr];
  assign cnt       = cnt_q;

  for (genvar j = 0; j < DEPTH; j++) begin : g_live
    logic [PW-1:0] off;
    assign off         = PW'(j) - rd_ptr;
    assign ent_live[j] = {1'b0, off} < cnt_q;
    assign ent_addr[j] = addr_mem[j];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (n_push != 2'd0) |-> (cnt_q + CNTW'(n_push) - CNTW'(pop) <= CNTW'(DEPTH))); // R6
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !pop) |=> ($stable(head_addr) && $stable(head_kind))); // R10
endmodule

// File: rtl/blk_prefetch_ctrl.sv
module blk_prefetch_ctrl #(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pf_always,
  input  logic          lk_valid,
  output logic          lk_ready,
  input  logic [AW-1:0] lk_addr,
  input  logic          lk_hit,
  input  logic          lk_touched,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_kind,
  output logic [CW-1:0] cnt_demand,
  output logic [CW-1:0] cnt_prefetch
);
  import pf_pkg::*;

  localparam int CNTW = $clog2(DEPTH) + 1;

  logic                     fire, want_dem, want_pf, dup, room_pf, pf_ok, pop;
  logic [AW-1:0]            pf_addr, a0;
  logic                     k0;
  logic [1:0]               n_push;
  logic [CNTW-1:0]          q_cnt, free_n;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0]         ent_live;
  logic [CW-1:0]            cnt_dem_q, cnt_pf_q;

  assign lk_ready = (q_cnt != CNTW'(DEPTH));
  assign fire     = lk_valid && lk_ready;

  pf_trigger #(.AW(AW)) u_trig (
    .pf_always (pf_always),
    .fire      (fire),
    .hit       (lk_hit),
    .touched   (lk_touched),
    .addr      (lk_addr),
    .want_dem  (want_dem),
    .want_pf   (want_pf),
    .pf_addr   (pf_addr)
  );

  pf_dup_check #(.AW(AW), .DEPTH(DEPTH)) u_dup (
    .ent_addr (ent_addr),
    .ent_live (ent_live),
    .probe    (pf_addr),
    .match    (dup)
  );

  always_comb begin
    free_n  = CNTW'(DEPTH) - q_cnt;
    room_pf = want_dem ? (free_n > CNTW'(1)) : (free_n != '0);
    pf_ok   = want_pf && room_pf && !dup;
    n_push  = {1'b0, want_dem} + {1'b0, pf_ok};
    a0      = want_dem ? lk_addr : pf_addr;
    k0      = want_dem ? REQ_DEMAND : REQ_PREFETCH;
  end

  assign mem_valid = (q_cnt != '0);
  assign pop       = mem_valid && mem_ready;

  pf_req_queue #(.AW(AW), .DEPTH(DEPTH)) u_q (
    .clk       (clk),
    .rst       (rst),
    .n_push    (n_push),
    .a0        (a0),
    .k0        (k0),
    .a1        (pf_addr),
    .k1        (REQ_PREFETCH),
    .pop       (pop),
    .head_addr (mem_addr),
    .head_kind (mem_kind),
    .cnt       (q_cnt),
    .ent_addr  (ent_addr),
    .ent_live  (ent_live)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_dem_q <= '0;
      cnt_pf_q  <= '0;
    end else begin
      cnt_dem_q <= cnt_dem_q + CW'(want_dem);
      cnt_pf_q  <= cnt_pf_q + CW'(pf_ok);
    end
  end

  assign cnt_demand   = cnt_dem_q;
  assign cnt_prefetch = cnt_pf_q;

  AST_MISS_DEMAND: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready && !lk_hit) |=> (cnt_demand == $past(cnt_demand) + CW'(1))); // R2
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready && lk_hit && !pf_always) |=> ($stable(cnt_prefetch) && $stable(cnt_demand))); // R3
  AST_TOUCHED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready && lk_hit && lk_touched) |=> $stable(cnt_prefetch)); // R5
  AST_STALL_NO_DEMAND: assert property (@(posedge clk) disable iff (rst)
    (!lk_ready) |=> $stable(cnt_demand)); // R6
endmodule

// File: tb/blk_prefetch_ctrl_test.sv
module blk_prefetch_ctrl_test;
  localparam int PERIOD = 10;
  localparam int AW = 16;
  localparam int DEPTH = 4;
  localparam int CW = 16;
  localparam int NV = 9;

  // mode, hit, touched, addr, n, a0, k0, a1, k1
  localparam logic [54:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 16'h0100, 2'd2, 16'h0100, 1'b0, 16'h0101, 1'b1},
    {1'b0, 1'b1, 1'b0, 16'h0200, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0},
    {1'b0, 1'b1, 1'b1, 16'h0300, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0},
    {1'b1, 1'b0, 1'b0, 16'h0400, 2'd2, 16'h0400, 1'b0, 16'h0401, 1'b1},
    {1'b1, 1'b1, 1'b0, 16'h0500, 2'd1, 16'h0501, 1'b1, 16'h0000, 1'b0},
    {1'b1, 1'b1, 1'b1, 16'h0600, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0},
    {1'b1, 1'b0, 1'b1, 16'h0700, 2'd2, 16'h0700, 1'b0, 16'h0701, 1'b1},
    {1'b0, 1'b0, 1'b0, 16'hFFFF, 2'd2, 16'hFFFF, 1'b0, 16'h0000, 1'b1},
    {1'b1, 1'b1, 1'b0, 16'hFFFF, 2'd1, 16'h0000, 1'b1, 16'h0000, 1'b0}
  };
  localparam string VTAG [NV] = '{"R2", "R3", "R3", "R2", "R4", "R5", "R2", "R8", "R8"};

  logic clk = 1'b0, rst = 1'b1;
  logic pf_always = 1'b0, lk_valid = 1'b0, lk_hit = 1'b0, lk_touched = 1'b0, mem_ready = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic lk_ready, mem_valid, mem_kind;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] cnt_demand, cnt_prefetch;

  int total = 0, bad = 0;
  int exp_dem = 0, exp_pf = 0;
  int n_got;
  logic [AW-1:0] got_a [8];
  logic got_k [8];

  always #(PERIOD/2) clk = ~clk;

  blk_prefetch_ctrl #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) uut (
    .clk(clk), .rst(rst), .pf_always(pf_always), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_touched(lk_touched), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_kind(mem_kind),
    .cnt_demand(cnt_demand), .cnt_prefetch(cnt_prefetch)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic m, input logic h, input logic t, input logic [AW-1:0] a);
    pf_always = m; lk_hit = h; lk_touched = t; lk_addr = a; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic drain(input int cycles);
    n_got = 0;
    mem_ready = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      if (mem_valid && n_got < 8) begin
        got_a[n_got] = mem_addr;
        got_k[n_got] = mem_kind;
        n_got++;
      end
      @(negedge clk);
    end
    mem_ready = 1'b0;
  endtask

  task automatic check_counters(input string tag);
    check({tag, " demand count"}, 32'(cnt_demand), 32'(exp_dem));
    check({tag, " prefetch count"}, 32'(cnt_prefetch), 32'(exp_pf));
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 mem_valid", 32'(mem_valid), 0);
    check("R1 lk_ready", 32'(lk_ready), 1);
    check("R1 cnt_demand", 32'(cnt_demand), 0);
    check("R1 cnt_prefetch", 32'(cnt_prefetch), 0);

    // table-driven policy vectors (R2 R3 R4 R5 R8 R9 R10)
    for (int v = 0; v < NV; v++) begin
      logic [54:0] e;
      int n;
      e = VEC[v];
      n = int'(e[35:34]);
      lookup(e[54], e[53], e[52], e[51:36]);
      drain(4);
      check({VTAG[v], " request count"}, 32'(n_got), 32'(n));
      if (n >= 1 && n_got >= 1) begin
        check({VTAG[v], " first addr"}, 32'(got_a[0]), 32'(e[33:18]));
        check({VTAG[v], " first kind (R10 order)"}, 32'(got_k[0]), 32'(e[17]));
      end
      if (n == 2 && n_got >= 2) begin
        check({VTAG[v], " second addr"}, 32'(got_a[1]), 32'(e[16:1]));
        check({VTAG[v], " second kind"}, 32'(got_k[1]), 32'(e[0]));
      end
      if (n == 2) begin exp_dem++; exp_pf++; end
      else if (n == 1) exp_pf++;
      check_counters("R9");
    end

    // R10 head holds while memory stalls
    lookup(1'b0, 1'b0, 1'b0, 16'h0A00);
    for (int c = 0; c < 3; c++) begin
      check("R10 hold valid", 32'(mem_valid), 1);
      check("R10 hold addr", 32'(mem_addr), 32'h0A00);
      check("R10 hold kind", 32'(mem_kind), 0);
      @(negedge clk);
    end
    drain(4);
    exp_dem++; exp_pf++;
    check("R10 drained count", 32'(n_got), 2);

    // R7 duplicate prefetch suppression
    lookup(1'b0, 1'b0, 1'b0, 16'h0B00);
    lookup(1'b1, 1'b1, 1'b0, 16'h0B00);
    lookup(1'b1, 1'b1, 1'b0, 16'h0B01);
    drain(6);
    exp_dem += 1; exp_pf += 2;
    check("R7 count", 32'(n_got), 3);
    if (n_got >= 3) begin
      check("R7 addr0", 32'(got_a[0]), 32'h0B00);
      check("R7 addr1", 32'(got_a[1]), 32'h0B01);
      check("R7 addr2", 32'(got_a[2]), 32'h0B02);
      check("R7 kind2", 32'(got_k[2]), 1);
    end
    check_counters("R7");

    // R6 full queue: prefetch dropped, demand stalled and kept
    lookup(1'b1, 1'b1, 1'b0, 16'h0050);
    lookup(1'b0, 1'b0, 1'b0, 16'h0010);
    lookup(1'b0, 1'b0, 1'b0, 16'h0020);
    exp_dem += 2; exp_pf += 2;
    check("R6 lk_ready when full", 32'(lk_ready), 0);
    check_counters("R6 drop");
    pf_always = 1'b0; lk_hit = 1'b0; lk_touched = 1'b0; lk_addr = 16'h0D00; lk_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 stalled demand not counted", 32'(cnt_demand), 32'(exp_dem));
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    check("R6 ready after pop", 32'(lk_ready), 1);
    @(negedge clk);
    lk_valid = 1'b0;
    exp_dem++;
    check_counters("R6 stall release");
    drain(8);
    check("R6 remaining count", 32'(n_got), 4);
    if (n_got >= 4) begin
      check("R6 e0", 32'(got_a[0]), 32'h0010);
      check("R6 e1", 32'(got_a[1]), 32'h0011);
      check("R6 e2", 32'(got_a[2]), 32'h0020);
      check("R6 e2 kind", 32'(got_k[2]), 0);
      check("R6 e3", 32'(got_a[3]), 32'h0D00);
    end
    check("R1 empty at end", 32'(mem_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule